// File: doc/BRIEF.md
# Latched-address eight-way data selector

This block picks one bit out of eight data inputs and presents it on a pair of outputs: one true and one inverted. Both the eight data bits and the three-bit select address pass through their own level-sensitive latches. Each latch group has its own active-low enable. A latch group follows its inputs while its enable is low and freezes when that enable goes high. This lets a system load an address or a data word once and then let the inputs move on.

Three output enables gate both outputs. Two of them are active low and one is active high. Only the single combination that activates all three lets the outputs drive. Every other combination floats them. A separate flag reports whether the outputs are being driven. Changing the enables never disturbs what the latches hold. An active-low asynchronous reset clears both latch groups so that a simulation starts from known values.

Top module: `latsel_top`

## Requirements
- R1: The latched address, read as an unsigned binary number with `sel[2]` as its most significant bit, names the data input that is routed to the output. Code k selects `d_in[k]`.
- R2: While `alat_n` is 0 the address latch follows `sel`. While `alat_n` is 1 it keeps its last value, and changes on `sel` have no effect on the outputs.
- R3: While `dlat_n` is 0 the data latches follow `d_in`. When `dlat_n` rises they keep the values present just before that edge, and later changes on `d_in` have no effect on the outputs.
- R4: While the outputs are driven, `y` equals the selected latched bit and `y_n` equals its inverse.
- R5: The outputs are driven, and `out_active` is 1, only when `oe_a_n`=0, `oe_b_n`=0 and `oe_c`=1. For the seven other combinations, `out_active` is 0 and both `y` and `y_n` are high impedance.
- R6: Changing `oe_a_n`, `oe_b_n` or `oe_c` never alters the contents of either latch group.
- R7: While `rst_n` is 0, both the address latch and the data latches are cleared to 0. After reset, with both latch enables at 1, a driven `y` reads 0 and `y_n` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both latch groups |
| d_in | input | 8 | Data inputs, bit k is source k |
| sel | input | 3 | Select address, bit 2 most significant |
| dlat_n | input | 1 | Data latch enable, transparent when 0 |
| alat_n | input | 1 | Address latch enable, transparent when 0 |
| oe_a_n | input | 1 | Output enable, active low |
| oe_b_n | input | 1 | Output enable, active low |
| oe_c | input | 1 | Output enable, active high |
| y | output | 1 | Selected bit, tri-stated when disabled |
| y_n | output | 1 | Inverse of the selected bit, tri-stated when disabled |
| out_active | output | 1 | 1 while both outputs are driven |

## Verification
Some checks run whenever the relevant signals change, with no clock involved. One confirms that the address decoder always yields exactly one select line. One flags any change of a latch's stored value while its enable is high. One confirms that the two outputs are inverses whenever they are driven. The bench scenarios are needed for the rest. These cover routing each address to the right input, the values kept across a rising enable edge, and the full table of enable combinations. They also cover the proof that toggling the output enables leaves both latch groups intact, and the cleared state after reset.

// File: rtl/latsel_pkg.sv
package latsel_pkg;
  localparam int unsigned DEF_SOURCES = 8;

  typedef enum logic {
    OUT_FLOAT = 1'b0,
    OUT_DRIVE = 1'b1
  } drive_e;
endpackage

// File: rtl/latsel_addr_latch.sv
module latsel_addr_latch #(
  parameter int unsigned AW = 3
) (
  input  logic          rst_n,
  input  logic          open_n,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_q
);
  always_latch begin
    if (!rst_n)       addr_q <= '0;
    else if (!open_n) addr_q <= addr_i;
  end

  // A held address must not move while the latch is closed.
  always @(addr_q) begin
    assert_addr_hold_R2: assert (!rst_n || !open_n)
      else $error("address latch changed while closed");
  end
endmodule

// File: rtl/latsel_data_latch.sv
module latsel_data_latch #(
  parameter int unsigned N = 8
) (
  input  logic         rst_n,
  input  logic         open_n,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] data_q
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_latch begin
      if (!rst_n)       data_q[k] <= 1'b0;
      else if (!open_n) data_q[k] <= data_i[k];
    end
  end

  always @(data_q) begin
    assert_data_hold_R3: assert (!rst_n || !open_n)
      else $error("data latch changed while closed");
  end
endmodule

// File: rtl/latsel_mux.sv
module latsel_mux #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  data,
  output logic          bit_o
);
  function automatic logic [N-1:0] onehot_of(input logic [AW-1:0] a);
    logic [N-1:0] v;
    v = '0;
    for (int k = 0; k < N; k++) v[k] = (a == AW'(k));
    return v;
  endfunction

  logic [N-1:0] hot;
  assign hot   = onehot_of(addr);
  assign bit_o = |(hot & data);

  always_comb begin
    assert_onehot_R1: assert ($countones(hot) == 1)
      else $error("decoder did not select exactly one source");
  end
endmodule

// File: rtl/latsel_out_stage.sv
module latsel_out_stage
  import latsel_pkg::*;
(
  input  logic oe_a_n,
  input  logic oe_b_n,
  input  logic oe_c,
  input  logic bit_i,
  output logic y,
  output logic y_n,
  output logic out_active
);
  drive_e mode;

  assign mode       = (!oe_a_n && !oe_b_n && oe_c) ? OUT_DRIVE : OUT_FLOAT;
  assign out_active = (mode == OUT_DRIVE);
  assign y          = out_active ? bit_i  : 1'bz;
  assign y_n        = out_active ? ~bit_i : 1'bz;

  always_comb begin
    if (out_active) begin
      assert_compl_R4: assert (y_n != y)
        else $error("outputs not complementary while driven");
    end
  end
endmodule

// File: rtl/latsel_top.sv
module latsel_top
  import latsel_pkg::*;
#(
  parameter int unsigned N  = DEF_SOURCES,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          rst_n,
  input  logic [N-1:0]  d_in,
  input  logic [AW-1:0] sel,
  input  logic          dlat_n,
  input  logic          alat_n,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  input  logic          oe_c,
  output logic          y,
  output logic          y_n,
  output logic          out_active
);
  logic [AW-1:0] addr_q;
  logic [N-1:0]  data_q;
  logic          pick;

  latsel_addr_latch #(.AW(AW)) u_addr (
    .rst_n (rst_n), .open_n(alat_n), .addr_i(sel), .addr_q(addr_q)
  );

  latsel_data_latch #(.N(N)) u_data (
    .rst_n (rst_n), .open_n(dlat_n), .data_i(d_in), .data_q(data_q)
  );

  latsel_mux #(.N(N), .AW(AW)) u_mux (
    .addr(addr_q), .data(data_q), .bit_o(pick)
  );

  latsel_out_stage u_out (
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .oe_c(oe_c), .bit_i(pick),
    .y(y), .y_n(y_n), .out_active(out_active)
  );
endmodule

// File: tb/latsel_top_test.sv
module latsel_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] d_in;
  logic [2:0] sel;
  logic       dlat_n, alat_n, oe_a_n, oe_b_n, oe_c;
  wire        y, y_n, out_active;
  int         total = 0;
  int         bad   = 0;

  always #2.5 clk = ~clk;

  latsel_top uut (
    .rst_n(rst_n), .d_in(d_in), .sel(sel), .dlat_n(dlat_n), .alat_n(alat_n),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .oe_c(oe_c),
    .y(y), .y_n(y_n), .out_active(out_active)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enable_out();
    oe_a_n = 1'b0; oe_b_n = 1'b0; oe_c = 1'b1;
  endtask

  // expect driven outputs carrying bit b
  task automatic expect_bit(input string tag, input logic b);
    chk({tag, " active"}, int'(out_active), 1);
    chk({tag, " y"},      int'(y),   int'(b));
    chk({tag, " y_n"},    int'(y_n), int'(!b));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; dlat_n = 1'b1; alat_n = 1'b1;
    d_in = 8'hFF; sel = 3'd5; enable_out();
    settle();
    rst_n = 1'b1;
    settle();
    expect_bit("R7 cleared", 1'b0);
  endtask

  task automatic t_select_all();
    logic [7:0] pats [3] = '{8'hA5, 8'h3C, 8'h01};
    dlat_n = 1'b0; alat_n = 1'b0; enable_out();
    foreach (pats[p]) begin
      for (int a = 0; a < 8; a++) begin
        d_in = pats[p]; sel = 3'(a);
        settle();
        expect_bit("R1 R4 route", pats[p][a]);
      end
    end
    // walking one: only the named input reaches the output
    for (int a = 0; a < 8; a++) begin
      d_in = 8'(1 << (7 - a)); sel = 3'(a);
      settle();
      expect_bit("R1 walking", (a == 7 - a) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_addr_hold();
    dlat_n = 1'b0; alat_n = 1'b0; enable_out();
    d_in = 8'b0000_1000; sel = 3'd3;
    settle();
    alat_n = 1'b1;
    settle();
    sel = 3'd5;
    settle();
    expect_bit("R2 address held", 1'b1);
    d_in = 8'b0010_0000;
    settle();
    expect_bit("R2 old address on new data", 1'b0);
    alat_n = 1'b0;
    settle();
    expect_bit("R2 reopened", 1'b1);
  endtask

  task automatic t_data_hold();
    dlat_n = 1'b0; alat_n = 1'b0; enable_out();
    d_in = 8'h40; sel = 3'd6;
    settle();
    dlat_n = 1'b1;
    settle();
    d_in = 8'hBF;
    settle();
    expect_bit("R3 data held", 1'b1);
    sel = 3'd0;
    settle();
    expect_bit("R3 held word other bit", 1'b0);
    dlat_n = 1'b0;
    settle();
    expect_bit("R3 reopened", 1'b1);
  endtask

  task automatic t_enables();
    dlat_n = 1'b0; alat_n = 1'b0; d_in = 8'h02; sel = 3'd1;
    for (int c = 0; c < 8; c++) begin
      oe_a_n = c[0]; oe_b_n = c[1]; oe_c = c[2];
      settle();
      chk("R5 enable combination", int'(out_active),
          (c == 4) ? 1 : 0);
    end
    enable_out();
    settle();
    expect_bit("R5 driven again", 1'b1);
  endtask

  task automatic t_oe_no_effect();
    dlat_n = 1'b0; alat_n = 1'b0; enable_out();
    d_in = 8'h80; sel = 3'd7;
    settle();
    dlat_n = 1'b1; alat_n = 1'b1;
    settle();
    for (int c = 0; c < 8; c++) begin
      oe_a_n = c[0]; oe_b_n = c[1]; oe_c = c[2];
      settle();
    end
    d_in = 8'h7F; sel = 3'd2;
    enable_out();
    settle();
    expect_bit("R6 latches kept through enable toggles", 1'b1);
    alat_n = 1'b0;
    settle();
    expect_bit("R6 data word kept", 1'b0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_select_all();
    t_addr_hold();
    t_data_hold();
    t_enables();
    t_oe_no_effect();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule